// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block brings an Ethernet PHY from power-on to a known link mode without software stepping through each register access. On a start pulse it runs one of three sequences over a register-level management handshake: a soft reset of the PHY, a read of the 32-bit PHY identifier, or an autonegotiation run. Each access goes to an external serial management master as a request carrying the opcode, PHY address, register address and write data. The master answers with a ready pulse and, for reads, the read data.

Every wait is measured in ticks of a slow time base, normally one per millisecond. The poll intervals and retry budgets are parameters, so a simulation can shrink them to a few clocks. The sequencer keeps each result on its outputs until the next command. A failed sequence leaves a sticky error flag that the next accepted start clears. A failed identifier read reports the all-ones identifier, which means that no PHY responded.

Top module: `phy_link_seq`

## Requirements
- R1: A read request drives `mdio_op` = 2'b10 and a write drives 2'b01, with `mdio_phy` equal to the `phy_addr` captured at start. `mdio_req` stays high with stable fields until `mdio_rdy`, and is low for at least one cycle after each acknowledge.
- R2: If a request is not acknowledged within IDLE_STEP_TICKS*IDLE_POLLS ticks, the sequence aborts, `err` rises and `busy` falls.
- R3: Command 2'd0 (soft reset) writes 16'h8000 to register 0. It then waits RST_STEP_TICKS ticks before each read of register 0 and completes with `done` once bit 15 reads 0.
- R4: If bit 15 of register 0 is still set on the RST_POLLS-th read, the soft reset fails with `err`, after exactly RST_POLLS reads.
- R5: Command 2'd1 reads register 2 then register 3 and reports `phy_id` = {reg2, reg3}. If either read fails, `phy_id` becomes 32'hFFFF_FFFF and `err` is set.
- R6: Command 2'd2 reads register 4 (local abilities), then reads register 0 and writes it back with bit 12 and bit 9 set, bit 10 cleared and all other bits kept.
- R7: After that write, register 1 is read after every AN_STEP_TICKS ticks until bit 5 is set. The run fails with `err` if bit 5 is still clear on the AN_POLLS-th read.
- R8: Once bit 5 is seen, register 5 is read and ANDed with the register 4 word. Bit 8 of the AND gives 100 full, bit 7 gives 100 half, bit 6 gives 10 full, and otherwise 10 half, in that priority. The result drives `speed_100` (1 = 100 Mb/s) and `full_dup` (1 = full duplex).
- R9: `done` is a one-cycle pulse on success. `err` holds until the next accepted start, which clears it. A start while `busy`, or a start with command 2'd3, is ignored.
- R10: After reset, `busy`, `done`, `err`, `mdio_req`, `phy_id`, `speed_100` and `full_dup` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for the selected command |
| cmd | input | 2 | 0 soft reset, 1 identifier, 2 autonegotiation, 3 none |
| phy_addr | input | 5 | PHY address, captured at start |
| tick | input | 1 | Time base pulse (one per millisecond in use) |
| mdio_req | output | 1 | Management request valid |
| mdio_op | output | 2 | 2'b10 read, 2'b01 write |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register address of the request |
| mdio_wdata | output | 16 | Write data |
| mdio_rdy | input | 1 | Request completed, read data valid |
| mdio_rdata | input | 16 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | Sticky failure or timeout flag |
| phy_id | output | 32 | PHY identifier |
| speed_100 | output | 1 | Resolved speed is 100 Mb/s |
| full_dup | output | 1 | Resolved mode is full duplex |

## Verification
A start accepted at a clock edge raises `busy`, clears `err` and presents the first request after that same edge. The final acknowledge, or the idle watchdog expiring, updates `phy_id` or the link mode, lowers `busy` and pulses `done` or raises `err` at one edge. The bench drives inputs and samples outputs on falling edges. It waits for `busy` to fall and reads `done`, `err` and the results at that falling edge, which is the only cycle in which `done` is high. The bench's PHY model acknowledges two cycles after a request appears and counts reads per register, so the number of polls before success or timeout is compared exactly.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [1:0] {
        CMD_RESET   = 2'd0,
        CMD_IDENT   = 2'd1,
        CMD_AUTONEG = 2'd2,
        CMD_NONE    = 2'd3
    } seq_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_GAP,
        FS_PAUSE
    } fsm_e;

    typedef enum logic [3:0] {
        ST_RST_WR,
        ST_RST_POLL,
        ST_ID_HI,
        ST_ID_LO,
        ST_AN_ADV,
        ST_AN_CTL_RD,
        ST_AN_CTL_WR,
        ST_AN_POLL,
        ST_AN_LP
    } step_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [4:0] REG_CTRL  = 5'd0;
    localparam logic [4:0] REG_STAT  = 5'd1;
    localparam logic [4:0] REG_ID_HI = 5'd2;
    localparam logic [4:0] REG_ID_LO = 5'd3;
    localparam logic [4:0] REG_ADV   = 5'd4;
    localparam logic [4:0] REG_LPA   = 5'd5;

    localparam int CTRL_RESET_BIT  = 15;
    localparam int CTRL_AN_EN_BIT  = 12;
    localparam int CTRL_ISO_BIT    = 10;
    localparam int CTRL_AN_RST_BIT = 9;
    localparam int STAT_AN_OK_BIT  = 5;
    localparam int ABIL_100FD_BIT  = 8;
    localparam int ABIL_100HD_BIT  = 7;
    localparam int ABIL_10FD_BIT   = 6;

    typedef struct packed {
        logic speed_100;
        logic full_dup;
    } link_mode_t;

    typedef struct packed {
        logic [1:0] op;
        logic [4:0] regad;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t step_fields(input step_e s);
        mgmt_cmd_t c;
        case (s)
            ST_RST_WR:    c = '{op: OP_WR, regad: REG_CTRL};
            ST_RST_POLL:  c = '{op: OP_RD, regad: REG_CTRL};
            ST_ID_HI:     c = '{op: OP_RD, regad: REG_ID_HI};
            ST_ID_LO:     c = '{op: OP_RD, regad: REG_ID_LO};
            ST_AN_ADV:    c = '{op: OP_RD, regad: REG_ADV};
            ST_AN_CTL_RD: c = '{op: OP_RD, regad: REG_CTRL};
            ST_AN_CTL_WR: c = '{op: OP_WR, regad: REG_CTRL};
            ST_AN_POLL:   c = '{op: OP_RD, regad: REG_STAT};
            default:      c = '{op: OP_RD, regad: REG_LPA};
        endcase
        return c;
    endfunction

    function automatic logic [15:0] ctl_restart(input logic [15:0] cur);
        logic [15:0] r;
        r = cur;
        r[CTRL_AN_EN_BIT]  = 1'b1;
        r[CTRL_AN_RST_BIT] = 1'b1;
        r[CTRL_ISO_BIT]    = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/phy_tick_count.sv
module phy_tick_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    assign hit = run && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && !hit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
    import phy_seq_pkg::*;
(
    input  logic [15:0] local_abil,
    input  logic [15:0] peer_abil,
    output link_mode_t  mode
);
    logic [15:0] common;

    assign common = local_abil & peer_abil;

    always_comb begin
        if (common[ABIL_100FD_BIT]) begin
            mode = '{speed_100: 1'b1, full_dup: 1'b1};
        end else if (common[ABIL_100HD_BIT]) begin
            mode = '{speed_100: 1'b1, full_dup: 1'b0};
        end else if (common[ABIL_10FD_BIT]) begin
            mode = '{speed_100: 1'b0, full_dup: 1'b1};
        end else begin
            mode = '{speed_100: 1'b0, full_dup: 1'b0};
        end
    end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
    import phy_seq_pkg::*;
#(
    parameter int IDLE_STEP_TICKS = 10,
    parameter int IDLE_POLLS      = 100,
    parameter int RST_STEP_TICKS  = 50,
    parameter int RST_POLLS       = 12,
    parameter int AN_STEP_TICKS   = 100,
    parameter int AN_POLLS        = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  cmd,
    input  logic [4:0]  phy_addr,
    input  logic        tick,
    output logic        mdio_req,
    output logic [1:0]  mdio_op,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    output logic [15:0] mdio_wdata,
    input  logic        mdio_rdy,
    input  logic [15:0] mdio_rdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [31:0] phy_id,
    output logic        speed_100,
    output logic        full_dup
);
    localparam int IDLE_LIMIT = IDLE_STEP_TICKS * IDLE_POLLS;
    localparam int STEP_MAX   = (RST_STEP_TICKS > AN_STEP_TICKS) ? RST_STEP_TICKS : AN_STEP_TICKS;
    localparam int TICK_MAX   = (IDLE_LIMIT > STEP_MAX) ? IDLE_LIMIT : STEP_MAX;
    localparam int CW         = $clog2(TICK_MAX + 1);
    localparam int POLL_MAX   = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
    localparam int PW         = $clog2(POLL_MAX + 1);

    fsm_e          fsm;
    step_e         step;
    logic [PW-1:0] polls;
    logic [15:0]   adv_q;
    logic [15:0]   id_hi_q;
    logic [15:0]   wdata_q;
    logic [4:0]    phy_q;
    link_mode_t    mode_q;
    link_mode_t    mode_new;
    mgmt_cmd_t     fields;
    logic          idle_hit;
    logic          pause_hit;
    logic [CW-1:0] pause_limit;
    logic          step_is_id;
    int            polls_next;

    assign fields      = step_fields(step);
    assign mdio_req    = (fsm == FS_REQ);
    assign mdio_op     = fields.op;
    assign mdio_reg    = fields.regad;
    assign mdio_phy    = phy_q;
    assign mdio_wdata  = wdata_q;
    assign speed_100   = mode_q.speed_100;
    assign full_dup    = mode_q.full_dup;
    assign pause_limit = (step == ST_RST_POLL) ? CW'(RST_STEP_TICKS) : CW'(AN_STEP_TICKS);
    assign step_is_id  = (step == ST_ID_HI) || (step == ST_ID_LO);
    assign polls_next  = int'(polls) + 1;

    phy_tick_count #(.CW(CW)) u_idle_wd (
        .clk   (clk),
        .rst   (rst),
        .run   (fsm == FS_REQ),
        .tick  (tick),
        .limit (CW'(IDLE_LIMIT)),
        .hit   (idle_hit)
    );

    phy_tick_count #(.CW(CW)) u_pause (
        .clk   (clk),
        .rst   (rst),
        .run   (fsm == FS_PAUSE),
        .tick  (tick),
        .limit (pause_limit),
        .hit   (pause_hit)
    );

    phy_mode_resolve u_resolve (
        .local_abil (adv_q),
        .peer_abil  (mdio_rdata),
        .mode       (mode_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm     <= FS_IDLE;
            step    <= ST_RST_WR;
            polls   <= '0;
            adv_q   <= '0;
            id_hi_q <= '0;
            wdata_q <= '0;
            phy_q   <= '0;
            mode_q  <= '0;
            phy_id  <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (fsm)
                FS_IDLE: begin
                    if (start && (seq_cmd_e'(cmd) != CMD_NONE)) begin
                        busy  <= 1'b1;
                        err   <= 1'b0;
                        phy_q <= phy_addr;
                        polls <= '0;
                        fsm   <= FS_REQ;
                        case (seq_cmd_e'(cmd))
                            CMD_RESET: begin
                                step    <= ST_RST_WR;
                                wdata_q <= 16'(1) << CTRL_RESET_BIT;
                            end
                            CMD_IDENT: step <= ST_ID_HI;
                            default:   step <= ST_AN_ADV;
                        endcase
                    end
                end
                FS_REQ: begin
                    if (mdio_rdy) begin
                        case (step)
                            ST_RST_WR: begin
                                polls <= '0;
                                step  <= ST_RST_POLL;
                                fsm   <= FS_PAUSE;
                            end
                            ST_RST_POLL: begin
                                if (!mdio_rdata[CTRL_RESET_BIT]) begin
                                    fsm  <= FS_IDLE;
                                    busy <= 1'b0;
                                    done <= 1'b1;
                                end else if (polls_next >= RST_POLLS) begin
                                    fsm  <= FS_IDLE;
                                    busy <= 1'b0;
                                    err  <= 1'b1;
                                end else begin
                                    polls <= polls + 1'b1;
                                    fsm   <= FS_PAUSE;
                                end
                            end
                            ST_ID_HI: begin
                                id_hi_q <= mdio_rdata;
                                step    <= ST_ID_LO;
                                fsm     <= FS_GAP;
                            end
                            ST_ID_LO: begin
                                phy_id <= {id_hi_q, mdio_rdata};
                                fsm    <= FS_IDLE;
                                busy   <= 1'b0;
                                done   <= 1'b1;
                            end
                            ST_AN_ADV: begin
                                adv_q <= mdio_rdata;
                                step  <= ST_AN_CTL_RD;
                                fsm   <= FS_GAP;
                            end
                            ST_AN_CTL_RD: begin
                                wdata_q <= ctl_restart(mdio_rdata);
                                step    <= ST_AN_CTL_WR;
                                fsm     <= FS_GAP;
                            end
                            ST_AN_CTL_WR: begin
                                polls <= '0;
                                step  <= ST_AN_POLL;
                                fsm   <= FS_PAUSE;
                            end
                            ST_AN_POLL: begin
                                if (mdio_rdata[STAT_AN_OK_BIT]) begin
                                    step <= ST_AN_LP;
                                    fsm  <= FS_GAP;
                                end else if (polls_next >= AN_POLLS) begin
                                    fsm  <= FS_IDLE;
                                    busy <= 1'b0;
                                    err  <= 1'b1;
                                end else begin
                                    polls <= polls + 1'b1;
                                    fsm   <= FS_PAUSE;
                                end
                            end
                            default: begin
                                mode_q <= mode_new;
                                fsm    <= FS_IDLE;
                                busy   <= 1'b0;
                                done   <= 1'b1;
                            end
                        endcase
                    end else if (idle_hit) begin
                        fsm  <= FS_IDLE;
                        busy <= 1'b0;
                        err  <= 1'b1;
                        if (step_is_id) begin
                            phy_id <= 32'hFFFF_FFFF;
                        end
                    end
                end
                FS_GAP: fsm <= FS_REQ;
                default: begin
                    if (pause_hit) begin
                        fsm <= FS_REQ;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  cmd,
    input logic        mdio_req,
    input logic [1:0]  mdio_op,
    input logic [4:0]  mdio_reg,
    input logic [15:0] mdio_wdata,
    input logic        mdio_rdy,
    input logic        busy,
    input logic        done,
    input logic        err
);
    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        mdio_req && !mdio_rdy |=> mdio_req || err);

    p_req_stable_r1: assert property (@(posedge clk) disable iff (rst)
        mdio_req && !mdio_rdy |=> !mdio_req ||
            ($stable(mdio_op) && $stable(mdio_reg) && $stable(mdio_wdata)));

    p_ack_gap_r1: assert property (@(posedge clk) disable iff (rst)
        mdio_req && mdio_rdy |=> !mdio_req);

    p_op_code_r1: assert property (@(posedge clk) disable iff (rst)
        mdio_req |-> (mdio_op == 2'b10 || mdio_op == 2'b01));

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_req);

    p_done_clean_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !err && !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err && !start |=> err);

    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        start && !busy && cmd != 2'd3 |=> busy && !err);

    p_none_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        start && !busy && cmd == 2'd3 |=> !busy);
endmodule

bind phy_link_seq phy_link_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmd        (cmd),
    .mdio_req   (mdio_req),
    .mdio_op    (mdio_op),
    .mdio_reg   (mdio_reg),
    .mdio_wdata (mdio_wdata),
    .mdio_rdy   (mdio_rdy),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/sim_phy_link_seq.sv
module sim_phy_link_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RST_POLLS  = 3;
    localparam int AN_POLLS   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [4:0]  phy_addr = 5'h0B;
    logic        tick = 1'b1;
    logic        mdio_req;
    logic [1:0]  mdio_op;
    logic [4:0]  mdio_phy;
    logic [4:0]  mdio_reg;
    logic [15:0] mdio_wdata;
    logic        mdio_rdy = 1'b0;
    logic [15:0] mdio_rdata = 16'h0;
    logic        busy;
    logic        done;
    logic        err;
    logic [31:0] phy_id;
    logic        speed_100;
    logic        full_dup;

    int checks = 0;
    int errors = 0;

    // PHY model state
    logic [15:0] regs [0:5];
    int rd_cnt [0:5];
    int rst_busy_cfg = 0;
    int an_wait_cfg  = 0;
    int rst_left = 0;
    int an_left  = 0;
    int mute = 0;
    int bad_phy = 0;
    logic [4:0]  last_wr_reg = '0;
    logic [15:0] last_wr_data = '0;
    logic        seen_done;
    logic        seen_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_link_seq #(
        .IDLE_STEP_TICKS (2),
        .IDLE_POLLS      (3),
        .RST_STEP_TICKS  (2),
        .RST_POLLS       (RST_POLLS),
        .AN_STEP_TICKS   (3),
        .AN_POLLS        (AN_POLLS)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .phy_addr(phy_addr),
        .tick(tick), .mdio_req(mdio_req), .mdio_op(mdio_op), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_rdy(mdio_rdy),
        .mdio_rdata(mdio_rdata), .busy(busy), .done(done), .err(err),
        .phy_id(phy_id), .speed_100(speed_100), .full_dup(full_dup)
    );

    // PHY model: acknowledges two cycles after a request appears
    initial begin
        int lat;
        int r;
        lat = 0;
        forever begin
            @(negedge clk);
            mdio_rdy = 1'b0;
            if (mdio_req && mute == 0) begin
                lat++;
                if (lat >= 2) begin
                    lat = 0;
                    r = int'(mdio_reg);
                    if (mdio_phy != phy_addr) bad_phy++;
                    if (mdio_op == 2'b01) begin
                        last_wr_reg  = mdio_reg;
                        last_wr_data = mdio_wdata;
                        if (r == 0) begin
                            if (mdio_wdata[15]) rst_left = rst_busy_cfg;
                            if (mdio_wdata[9])  an_left  = an_wait_cfg;
                            regs[0] = mdio_wdata & ~16'h8200;
                        end else if (r < 6) begin
                            regs[r] = mdio_wdata;
                        end
                    end else begin
                        if (r < 6) rd_cnt[r]++;
                        if (r == 0) begin
                            if (rst_left > 0) begin
                                rst_left--;
                                mdio_rdata = regs[0] | 16'h8000;
                            end else begin
                                mdio_rdata = regs[0];
                            end
                        end else if (r == 1) begin
                            if (an_left > 0) begin
                                an_left--;
                                mdio_rdata = regs[1] & ~16'h0020;
                            end else begin
                                mdio_rdata = regs[1] | 16'h0020;
                            end
                        end else if (r < 6) begin
                            mdio_rdata = regs[r];
                        end else begin
                            mdio_rdata = 16'h0;
                        end
                    end
                    mdio_rdy = 1'b1;
                end
            end else begin
                lat = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 6; i++) begin
            rd_cnt[i] = 0;
        end
        regs[0] = 16'h0000; regs[1] = 16'h7849; regs[2] = 16'h0000;
        regs[3] = 16'h0000; regs[4] = 16'h0000; regs[5] = 16'h0000;
        mute = 0; rst_left = 0; an_left = 0; bad_phy = 0;
        last_wr_reg = '0; last_wr_data = '0;
    endtask

    task automatic run_cmd(input logic [1:0] c);
        @(negedge clk);
        start = 1'b1; cmd = c;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000 && busy; i++) begin
            @(negedge clk);
        end
        seen_done = done;
        seen_err  = err;
        if (busy) begin
            checks++; errors++;
            $display("FAIL run_cmd busy stuck actual=1 expected=0");
        end
    endtask

    task automatic t_reset_state();
        chk("R10 busy", 32'(busy), 0);
        chk("R10 done", 32'(done), 0);
        chk("R10 err", 32'(err), 0);
        chk("R10 mdio_req", 32'(mdio_req), 0);
        chk("R10 phy_id", phy_id, 0);
        chk("R10 mode", {30'd0, speed_100, full_dup}, 0);
    endtask

    task automatic t_soft_reset_ok();
        clear_model();
        rst_busy_cfg = RST_POLLS - 1;
        run_cmd(2'd0);
        chk("R3 done", 32'(seen_done), 1);
        chk("R3 err", 32'(seen_err), 0);
        chk("R3 write reg", 32'(last_wr_reg), 0);
        chk("R3 write data", 32'(last_wr_data), 32'h8000);
        chk("R3 reads at limit", rd_cnt[0], RST_POLLS);
        chk("R1 phy address", bad_phy, 0);
    endtask

    task automatic t_soft_reset_timeout();
        clear_model();
        rst_busy_cfg = RST_POLLS + 2;
        run_cmd(2'd0);
        chk("R4 err", 32'(seen_err), 1);
        chk("R4 done", 32'(seen_done), 0);
        chk("R4 read count", rd_cnt[0], RST_POLLS);
    endtask

    task automatic t_ident_ok();
        clear_model();
        phy_addr = 5'h15;
        regs[2] = 16'h0022; regs[3] = 16'h1622;
        run_cmd(2'd1);
        chk("R5 done", 32'(seen_done), 1);
        chk("R5 phy_id", phy_id, 32'h0022_1622);
        chk("R1 phy address", bad_phy, 0);
        chk("R5 reads", rd_cnt[2] * 16 + rd_cnt[3], 17);
        phy_addr = 5'h0B;
    endtask

    task automatic t_ident_fail();
        clear_model();
        mute = 1;
        run_cmd(2'd1);
        chk("R2 err on silent master", 32'(seen_err), 1);
        chk("R5 no-PHY id", phy_id, 32'hFFFF_FFFF);
        chk("R2 request dropped", 32'(mdio_req), 0);
        repeat (5) @(negedge clk);
        chk("R9 err sticky", 32'(err), 1);
        mute = 0;
    endtask

    task automatic t_autoneg(input logic [15:0] adv, input logic [15:0] lpa,
                             input int wait_polls, input logic sp, input logic fd,
                             input string tag);
        clear_model();
        regs[0] = 16'h0500; regs[4] = adv; regs[5] = lpa;
        an_wait_cfg = wait_polls;
        run_cmd(2'd2);
        chk({"R8 done ", tag}, 32'(seen_done), 1);
        chk({"R8 mode ", tag}, {30'd0, speed_100, full_dup}, {30'd0, sp, fd});
        chk({"R6 ctrl write ", tag}, 32'(last_wr_data), 32'h1300);
        chk({"R6 adv read ", tag}, rd_cnt[4], 1);
        chk({"R7 status reads ", tag}, rd_cnt[1], wait_polls + 1);
    endtask

    task automatic t_autoneg_timeout();
        clear_model();
        regs[4] = 16'h01E1; regs[5] = 16'h01E1;
        an_wait_cfg = AN_POLLS + 5;
        run_cmd(2'd2);
        chk("R7 err", 32'(seen_err), 1);
        chk("R7 status reads", rd_cnt[1], AN_POLLS);
        chk("R7 partner not read", rd_cnt[5], 0);
    endtask

    task automatic t_start_rules();
        // err is set from the previous test; cmd 3 must not touch it
        @(negedge clk);
        start = 1'b1; cmd = 2'd3;
        @(negedge clk);
        start = 1'b0;
        chk("R9 cmd3 ignored busy", 32'(busy), 0);
        chk("R9 cmd3 keeps err", 32'(err), 1);
        // start while busy is ignored
        clear_model();
        rst_busy_cfg = 1;
        @(negedge clk);
        start = 1'b1; cmd = 2'd0;
        @(negedge clk);
        start = 1'b0;
        chk("R9 accepted start clears err", 32'(err), 0);
        chk("R9 busy after start", 32'(busy), 1);
        repeat (2) @(negedge clk);
        start = 1'b1; cmd = 2'd1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000 && busy; i++) begin
            @(negedge clk);
        end
        chk("R9 done pulse", 32'(done), 1);
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 0);
        chk("R9 busy start ignored", rd_cnt[2] + rd_cnt[3], 0);
        chk("R3 reset reads", rd_cnt[0], 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_soft_reset_ok();
        t_soft_reset_timeout();
        t_ident_ok();
        t_ident_fail();
        t_autoneg(16'h01E1, 16'h01E1, 2, 1'b1, 1'b1, "100FD");
        t_autoneg(16'h01E1, 16'h00A1, 3, 1'b1, 1'b0, "100HD");
        t_autoneg(16'h01E1, 16'h0041, 0, 1'b0, 1'b1, "10FD");
        t_autoneg(16'h01E1, 16'h0021, 1, 1'b0, 1'b0, "10HD");
        t_autoneg(16'h0061, 16'h01E1, 1, 1'b0, 1'b1, "local limits");
        t_autoneg_timeout();
        t_start_rules();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule